// File: doc/BRIEF.md
# Memory Bandwidth Monitor Unit

This unit sits beside a memory controller and watches the stream of transactions the controller grants. Every granted transaction carries a major port number (0 to 31) and a sub-port number (0 to 15). The unit keeps six 32-bit counters. Two are global: one counts request strobes and one counts grant strobes. The other four are per-channel grant counters, and each passes grants through its own two-level filter. Each grant stands for one 16-byte data beat, so software turns a count into bytes by multiplying it by 16.

A measurement is one window. Software programs the filters and a timer load value, then sets the enable bit together with the timer-mode bit. The timer then runs for exactly the loaded number of clock cycles. When it runs out, counting stops, the enable bit drops and the interrupt line rises. The counts hold until software reads them. Software acknowledges the interrupt by writing bit 30 of control back as one. When the timer-mode bit is clear, the unit counts for as long as the enable bit stays set.

All registers sit behind a word-addressed read/write port. A write takes effect at the clock edge. A read returns data combinationally from the addressed word.

Top module: `bwmon_top`

## Requirements
- R1: After reset, every register word from offset 0x20 to 0x2f reads zero and `irq` is low.
- R2: While counting is active, counter 0x29 adds one for each cycle with `req_vld` high, and counter 0x2a adds one for each cycle with `gnt_vld` high, whatever the channel filters hold.
- R3: Channel n (filter words 0x21+2n and 0x22+2n, count word 0x2b+n) counts a grant from port p when bit 23 of word 0x21+2n is clear, bit p of word 0x21+2n is set and the low 16 bits of word 0x22+2n are all ones. With any other sub-port mask value, or with both words zero, the channel counts nothing.
- R4: When bit 23 of word 0x21+2n is set, channel n is in device mode. It counts only grants whose port is 23 and whose sub-port number s has bit s set in word 0x22+2n. All other port bits are ignored in this mode.
- R5: Control word 0x20 bits 3:0 enable channels 0 to 3. A channel whose bit is clear does not count.
- R6: Writing control with bit 31 set while the unit is disabled, and with bit 20 set, loads the timer from word 0x2f (value L). Grants in the next L cycles are counted. The cycle after those L cycles counts nothing, and at its edge the interrupt sets and bit 31 clears. Control bit 30 reads the interrupt flag, and `irq` mirrors it.
- R7: No counter changes while the interrupt flag is set or while bit 31 is clear.
- R8: The interrupt flag clears only on a write to control whose data has bit 30 set or is all zeros. Any other write to control leaves the flag set.
- R9: A write to a count word (0x29 to 0x2e) loads the written value, so writing zero clears it.
- R10: A counter that reads 0xFFFFFFFF stays at that value when further events arrive.
- R11: With bit 20 clear, enabling the unit counts with no time limit and never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| req_vld | input | 1 | One transaction request this cycle |
| gnt_vld | input | 1 | One transaction grant this cycle |
| gnt_port | input | 5 | Major port number of the grant |
| gnt_sub | input | 4 | Sub-port number of the grant |
| irq | output | 1 | Window-complete interrupt |

## Verification
The hardest case to reach from the ports is the exact edge of a window. The last counted grant and the first ignored one sit one cycle apart. At that same moment three things must agree: the counters freeze, the enable bit drops and the interrupt rises. The bench drives a new random grant in every cycle, starting with the enable write. It runs a few cycles past the window and accumulates its expected counts only for the first L cycles. It repeats this with window lengths of zero, one and several hundred, and rotates device-mode, port-mask, blocked and empty filters across the channels. A second hard case is a counter that is frozen while enable is still set, so that only the interrupt flag is holding it. The bench reaches this by re-enabling the unit without acknowledging the interrupt.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NCHAN     = 4;
  localparam int unsigned PORT_W    = 5;
  localparam int unsigned SUB_W     = 4;
  localparam int unsigned NPORT     = 1 << PORT_W;
  localparam int unsigned NSUB      = 1 << SUB_W;
  localparam int unsigned NCNT      = 2 + NCHAN;

  // port number that carries sub-port traffic, and the mask bit selecting it
  localparam int unsigned DEV_PORT  = 23;
  localparam int unsigned DEV_BIT   = 23;

  // control word bit positions
  localparam int unsigned BIT_EN    = 31;
  localparam int unsigned BIT_IRQ   = 30;
  localparam int unsigned BIT_TMODE = 20;

  // word offsets
  localparam int unsigned OFF_CTRL  = 'h20;
  localparam int unsigned OFF_FLT   = 'h21;
  localparam int unsigned OFF_CNT   = 'h29;
  localparam int unsigned OFF_TMR   = 'h2f;

  typedef struct packed {
    logic             en;
    logic             irq;
    logic             tmode;
    logic [NCHAN-1:0] chen;
  } ctl_t;

  function automatic logic [ADDR_W-1:0] waddr(input int unsigned off);
    return ADDR_W'(off);
  endfunction
endpackage

// File: rtl/bwmon_window.sv
module bwmon_window
  import bwmon_pkg::*;
#(
  parameter int unsigned TMR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              tmr_we,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl,
  output logic              count_en,
  output logic [TMR_W-1:0]  tload
);
  ctl_t             ctl_q, ctl_d;
  logic [TMR_W-1:0] tload_q, tcnt_q, tcnt_d;
  logic             tcnt_en;
  logic             active, expire, en_rise, irq_clr;

  assign active  = ctl_q.en && !ctl_q.irq;
  assign expire  = active && ctl_q.tmode && (tcnt_q == '0);
  assign en_rise = ctrl_we && wdata[BIT_EN] && !ctl_q.en;
  assign irq_clr = ctrl_we && (wdata[BIT_IRQ] || (wdata == '0));

  always_comb begin
    ctl_d = ctl_q;
    if (ctrl_we) begin
      ctl_d.en    = wdata[BIT_EN];
      ctl_d.tmode = wdata[BIT_TMODE];
      ctl_d.chen  = wdata[NCHAN-1:0];
    end
    if (irq_clr) ctl_d.irq = 1'b0;
    if (expire) begin
      ctl_d.en  = 1'b0;
      ctl_d.irq = 1'b1;
    end
  end

  always_comb begin
    tcnt_d  = tcnt_q;
    tcnt_en = 1'b0;
    if (en_rise && wdata[BIT_TMODE]) begin
      tcnt_d  = tload_q;
      tcnt_en = 1'b1;
    end else if (active && ctl_q.tmode && (tcnt_q != '0)) begin
      tcnt_d  = tcnt_q - 1'b1;
      tcnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      tload_q <= '0;
      tcnt_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (tmr_we)  tload_q <= wdata[TMR_W-1:0];
      if (tcnt_en) tcnt_q  <= tcnt_d;
    end
  end

  assign ctl      = ctl_q;
  assign count_en = active && !expire;
  assign tload    = tload_q;
endmodule

// File: rtl/bwmon_filter.sv
module bwmon_filter
  import bwmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pm_we,
  input  logic              sm_we,
  input  logic [NPORT-1:0]  pm_wdata,
  input  logic [NSUB-1:0]   sm_wdata,
  input  logic [PORT_W-1:0] port,
  input  logic [SUB_W-1:0]  sub,
  output logic [NPORT-1:0]  pm,
  output logic [NSUB-1:0]   sm,
  output logic              hit
);
  logic [NPORT-1:0] pm_q;
  logic [NSUB-1:0]  sm_q;
  logic             dev_mode, dev_hit, major_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q <= '0;
      sm_q <= '0;
    end else begin
      if (pm_we) pm_q <= pm_wdata;
      if (sm_we) sm_q <= sm_wdata;
    end
  end

  assign dev_mode  = pm_q[DEV_BIT];
  assign dev_hit   = (port == PORT_W'(DEV_PORT)) && sm_q[sub];
  assign major_hit = pm_q[port] && (&sm_q);
  assign hit       = dev_mode ? dev_hit : major_hit;
  assign pm        = pm_q;
  assign sm        = sm_q;
endmodule

// File: rtl/bwmon_satcnt.sv
module bwmon_satcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  logic [CNT_W-1:0] q_q, q_d;
  logic             q_en;

  always_comb begin
    q_d  = q_q;
    q_en = 1'b0;
    if (ld) begin
      q_d  = ld_val;
      q_en = 1'b1;
    end else if (inc && (q_q != '1)) begin
      q_d  = q_q + 1'b1;
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
  import bwmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned TMR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_vld,
  input  logic              gnt_vld,
  input  logic [PORT_W-1:0] gnt_port,
  input  logic [SUB_W-1:0]  gnt_sub,
  output logic              irq
);
  ctl_t                        ctl;
  logic                        count_en;
  logic [TMR_W-1:0]            tload;
  logic                        ctrl_we, tmr_we;
  logic [NCHAN-1:0]            hit, dev_sel;
  logic [NCHAN-1:0][NPORT-1:0] pm_q;
  logic [NCHAN-1:0][NSUB-1:0]  sm_q;
  logic [NCNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NCNT-1:0]             cnt_ld, cnt_inc;
  logic                        ctl_en;

  assign ctrl_we = reg_we && (reg_addr == waddr(OFF_CTRL));
  assign tmr_we  = reg_we && (reg_addr == waddr(OFF_TMR));

  bwmon_window #(.TMR_W(TMR_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .tmr_we   (tmr_we),
    .wdata    (reg_wdata),
    .ctl      (ctl),
    .count_en (count_en),
    .tload    (tload)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    bwmon_filter u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .pm_we    (reg_we && (reg_addr == waddr(OFF_FLT + 2*i))),
      .sm_we    (reg_we && (reg_addr == waddr(OFF_FLT + 2*i + 1))),
      .pm_wdata (reg_wdata[NPORT-1:0]),
      .sm_wdata (reg_wdata[NSUB-1:0]),
      .port     (gnt_port),
      .sub      (gnt_sub),
      .pm       (pm_q[i]),
      .sm       (sm_q[i]),
      .hit      (hit[i])
    );
    assign dev_sel[i] = pm_q[i][DEV_BIT];
  end

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    if (j == 0) begin : g_req
      assign cnt_inc[j] = count_en && req_vld;
    end else if (j == 1) begin : g_gnt
      assign cnt_inc[j] = count_en && gnt_vld;
    end else begin : g_ch
      assign cnt_inc[j] = count_en && gnt_vld && ctl.chen[j-2] && hit[j-2];
    end
    assign cnt_ld[j] = reg_we && (reg_addr == waddr(OFF_CNT + j));
    bwmon_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cnt_ld[j]),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .inc    (cnt_inc[j]),
      .q      (cnt_q[j])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == waddr(OFF_CTRL)) begin
      reg_rdata[BIT_EN]      = ctl.en;
      reg_rdata[BIT_IRQ]     = ctl.irq;
      reg_rdata[BIT_TMODE]   = ctl.tmode;
      reg_rdata[NCHAN-1:0]   = ctl.chen;
    end
    if (reg_addr == waddr(OFF_TMR)) reg_rdata = DATA_W'(tload);
    for (int i = 0; i < NCHAN; i++) begin
      if (reg_addr == waddr(OFF_FLT + 2*i))     reg_rdata = DATA_W'(pm_q[i]);
      if (reg_addr == waddr(OFF_FLT + 2*i + 1)) reg_rdata = DATA_W'(sm_q[i]);
    end
    for (int j = 0; j < NCNT; j++) begin
      if (reg_addr == waddr(OFF_CNT + j)) reg_rdata = DATA_W'(cnt_q[j]);
    end
  end

  assign ctl_en = ctl.en;
  assign irq    = ctl.irq;
endmodule

// File: rtl/bwmon_chk.sv
module bwmon_chk
  import bwmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic                       gnt_vld,
  input logic [PORT_W-1:0]          gnt_port,
  input logic                       irq,
  input logic                       en,
  input logic [NCHAN-1:0]           hit,
  input logic [NCHAN-1:0]           dev_sel,
  input logic [NCNT-1:0][CNT_W-1:0] cnt_q,
  input logic [NCNT-1:0]            cnt_ld
);
  logic irq_ack;
  assign irq_ack = reg_we && (reg_addr == waddr(OFF_CTRL)) &&
                   (reg_wdata[BIT_IRQ] || (reg_wdata == '0));

  // R6: the window end drops enable in the same edge as the interrupt rises
  assert_window_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !en);

  // R8: flag is sticky until acknowledged
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R7: no grant counting under a pending interrupt
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cnt_ld[1]) |=> $stable(cnt_q[1]));

  // R2: grant total moves only on grants
  assert_grant_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && !cnt_ld[1]) |=> $stable(cnt_q[1]));

  for (genvar i = 0; i < NCHAN; i++) begin : g_dev
    // R4: a device-mode channel only ever matches the device port
    assert_devport_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && dev_sel[i]) |-> (gnt_port == PORT_W'(DEV_PORT)));
  end

  for (genvar j = 0; j < NCNT; j++) begin : g_sat
    // R10: saturated counters hold
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q[j] == '1) && !cnt_ld[j]) |=> (cnt_q[j] == '1));
  end
endmodule

bind bwmon_top bwmon_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .gnt_vld   (gnt_vld),
  .gnt_port  (gnt_port),
  .irq       (irq),
  .en        (ctl_en),
  .hit       (hit),
  .dev_sel   (dev_sel),
  .cnt_q     (cnt_q),
  .cnt_ld    (cnt_ld)
);

// File: tb/test_bwmon_top.sv
module test_bwmon_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_vld, gnt_vld;
  logic [4:0]  gnt_port;
  logic [3:0]  gnt_sub;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] cfg_pm [4];
  logic [15:0] cfg_sm [4];
  logic [31:0] exp_cnt [6];

  always #4 clk = ~clk;

  bwmon_top i_bwmon_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_vld(req_vld),
    .gnt_vld(gnt_vld), .gnt_port(gnt_port), .gnt_sub(gnt_sub), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // reference filter decision, written from R3 and R4
  function automatic bit ref_hit(input logic [31:0] pm, input logic [15:0] sm,
                                 input logic [4:0] p, input logic [3:0] s);
    if (pm[23]) return (p == 5'd23) && sm[s];
    return pm[p] && (sm == 16'hFFFF);
  endfunction

  task automatic rand_event();
    req_vld  = 1'($urandom % 2);
    gnt_vld  = ($urandom % 4) != 0;
    gnt_port = ($urandom % 2) ? 5'd23 : 5'($urandom % 32);
    gnt_sub  = 4'($urandom % 16);
  endtask

  task automatic idle_event();
    req_vld = 1'b0; gnt_vld = 1'b0; gnt_port = '0; gnt_sub = '0;
  endtask

  task automatic run_window(input int it, input int len, input logic [3:0] chen);
    logic [31:0] v;
    string tag;
    wr(8'h20, 32'h0);
    for (int j = 0; j < 6; j++) wr(8'(8'h29 + j), 32'h0);
    for (int i = 0; i < 4; i++) begin
      wr(8'(8'h21 + 2*i), cfg_pm[i]);
      wr(8'(8'h22 + 2*i), 32'(cfg_sm[i]));
    end
    wr(8'h2f, 32'(len));
    for (int j = 0; j < 6; j++) exp_cnt[j] = 0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h20;
    reg_wdata = 32'h8010_0000 | 32'(chen);
    rand_event();
    @(negedge clk);
    reg_we = 1'b0;
    for (int k = 1; k <= len + 4; k++) begin
      rand_event();
      if (k <= len) begin
        if (req_vld) exp_cnt[0]++;
        if (gnt_vld) begin
          exp_cnt[1]++;
          for (int i = 0; i < 4; i++)
            if (chen[i] && ref_hit(cfg_pm[i], cfg_sm[i], gnt_port, gnt_sub)) exp_cnt[2+i]++;
        end
      end
      @(negedge clk);
    end
    idle_event();
    rd(8'h29, v); chk($sformatf("R2 req total win%0d", it), v, exp_cnt[0]);
    rd(8'h2a, v); chk($sformatf("R2 grant total win%0d", it), v, exp_cnt[1]);
    for (int i = 0; i < 4; i++) begin
      if (!chen[i]) tag = "R5";
      else if (cfg_pm[i][23]) tag = "R4";
      else tag = "R3";
      rd(8'(8'h2b + i), v);
      chk($sformatf("%s chan%0d win%0d", tag, i, it), v, exp_cnt[2+i]);
    end
    chk($sformatf("R6 irq win%0d", it), 32'(irq), 32'd1);
    rd(8'h20, v);
    chk($sformatf("R6 ctrl en/irq bits win%0d", it), 32'(v[31:30]), 32'd1);
  endtask

  initial begin
    logic [31:0] v, held;
    logic [3:0]  chen;
    int          len, role;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle_event();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 8'h20; a <= 8'h2f; a++) begin
      rd(8'(a), v); chk($sformatf("R1 reset word %0h", a), v, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // sweep of windows with rotating filter roles
    for (int it = 0; it < 8; it++) begin
      for (int i = 0; i < 4; i++) begin
        role = (i + it) % 4;
        case (role)
          0: begin cfg_pm[i] = $urandom | 32'h0080_0000; cfg_sm[i] = 16'($urandom); end
          1: begin cfg_pm[i] = $urandom & ~32'h0080_0000; cfg_sm[i] = 16'hFFFF; end
          2: begin cfg_pm[i] = $urandom & ~32'h0080_0000;
                   cfg_sm[i] = 16'hFFFF ^ (16'h1 << ($urandom % 16)); end
          default: begin cfg_pm[i] = 32'h0; cfg_sm[i] = 16'h0; end
        endcase
      end
      chen = (it % 3 == 2) ? 4'($urandom % 16) : 4'hF;
      len  = (it == 0) ? 0 : (it == 1) ? 1 : 60 * it + 3;
      run_window(it, len, chen);
    end

    // R8 / R7: re-enable without acknowledging; flag holds the counts
    rd(8'h2a, held);
    wr(8'h20, 32'h0000_000F);
    chk("R8 irq kept after write without bit30", 32'(irq), 32'd1);
    wr(8'h20, 32'h8000_000F);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); gnt_vld = 1'b1; req_vld = 1'b1; gnt_port = 5'd3;
    end
    @(negedge clk); idle_event();
    rd(8'h2a, v); chk("R7 grant total frozen under irq", v, held);
    chk("R8 irq still set", 32'(irq), 32'd1);
    wr(8'h20, 32'h4000_0000);
    chk("R8 irq cleared by bit30 write", 32'(irq), 32'd0);

    // R9: count word load
    wr(8'h2d, 32'h0000_1234);
    rd(8'h2d, v); chk("R9 count load", v, 32'h0000_1234);
    wr(8'h2d, 32'h0);
    rd(8'h2d, v); chk("R9 count clear", v, 32'h0);

    // R10 / R11: free-running mode with near-full counters
    wr(8'h21, 32'h0000_0020);
    wr(8'h22, 32'h0000_FFFF);
    wr(8'h2b, 32'h0);
    wr(8'h29, 32'hFFFF_FFFD);
    wr(8'h2a, 32'hFFFF_FFFE);
    wr(8'h2f, 32'd2);
    wr(8'h20, 32'h8000_0001);
    for (int k = 0; k < 5; k++) begin
      gnt_vld = 1'b1; req_vld = 1'b1; gnt_port = 5'd5; gnt_sub = 4'd0;
      @(negedge clk);
    end
    idle_event();
    rd(8'h29, v); chk("R10 req total saturates", v, 32'hFFFF_FFFF);
    rd(8'h2a, v); chk("R10 grant total saturates", v, 32'hFFFF_FFFF);
    rd(8'h2b, v); chk("R11 untimed count past timer value", v, 32'd5);
    chk("R11 no irq in untimed mode", 32'(irq), 32'd0);
    wr(8'h20, 32'h0);
    for (int k = 0; k < 3; k++) begin
      gnt_vld = 1'b1; gnt_port = 5'd5;
      @(negedge clk);
    end
    idle_event();
    rd(8'h2b, v); chk("R7 no count while disabled", v, 32'd5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule